// File: doc/BRIEF.md
# Translation Table Maintenance Command Engine

This block owns a set of I/O translation tables, each a run of 64-bit entries mapping one bus page to one memory page. It accepts one maintenance command at a time. The four commands write one entry, read one entry, write one value over a run of pages, or copy a run of entries from a list held in memory. Each command names its target table by a 64-bit identifier. The block replies with a one-bit status (success or parameter error) and, for a read, the entry value.

Each table has its own identifier, bus base offset, page size (given as a shift) and entry count. All four are fixed by parameters. The entry slot for a bus address is the page-aligned address minus the table's bus offset, shifted right by the page shift. The block works through the pages of a multi-page command one at a time, and it stops at the first page whose slot lies outside the table. List entries are fetched through a simple read port. That port returns one 64-bit word per request, and the first byte in memory is the most significant byte of the entry. The block sends each request only after the previous word has arrived.

Top module: `tt_cmd_engine`

## Requirements
- R1: After reset, every entry of every table reads as zero, and `busy` and `done` are low.
- R2: A command whose identifier has any of bits 63..32 set, or whose low 32 bits match no table, ends with `done_err`=1 and writes no entry.
- R3: The command address is rounded down to a multiple of the table's page size before any slot is computed, so the offset within a page never affects the target slot.
- R4: A write-one command (opcode 0) stores `cmd_data` at slot (aligned address − bus offset) >> page shift. If that slot is not below the entry count, it returns `done_err`=1 and stores nothing.
- R5: A read-one command (opcode 1) uses the slot rule of R4 and returns the stored entry on `done_data` with `done_err`=0. Out of range, it returns `done_err`=1 and `done_data`=0.
- R6: A list-copy command (opcode 3) with a count above 512, or with a list address (`cmd_data`) whose bits 11..0 are not all zero, ends with `done_err`=1 and issues no memory read.
- R7: A list-copy reads word i at list address + 8·i. Bits 7..0 of `mem_rdata` are the most significant byte of the entry. Word i goes to the page i pages above the aligned start address.
- R8: A fill command (opcode 2) with a count larger than the table's entry count ends with `done_err`=1. Otherwise `cmd_data` is stored into `cmd_count` consecutive pages.
- R9: A multi-page command that reaches a slot outside the table stops there with `done_err`=1. Pages already stored keep their new values. A list-copy issues no read after the failing word.
- R10: A fill or list-copy with a count of zero ends with `done_err`=1 and changes no entry.
- R11: A command is taken only while `busy` is low. `cmd_valid` while busy is ignored. `busy` rises the cycle after acceptance, and `done` is a single-cycle pulse after which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 write-one, 1 read-one, 2 fill, 3 list-copy |
| cmd_tid | input | 64 | Table identifier |
| cmd_addr | input | 64 | Bus address of the first page |
| cmd_data | input | 64 | Entry value (write-one, fill) or list address (list-copy) |
| cmd_count | input | CNT_W | Page count for fill and list-copy |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | 1 = parameter error, 0 = success, valid with done |
| done_data | output | 64 | Entry value for read-one, else zero |
| mem_req | output | 1 | List word read request |
| mem_addr | output | 64 | Byte address of the requested list word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data, lowest-address byte in bits 7..0 |

## Verification
Two functions can fall in the same cycle: a running fill storing into the table, and a new command arriving on the command port. The bench starts a 16-page fill and holds a write-one command on the port for several cycles while the fill runs. It then reads back every entry of both tables. The fill value must appear in all 16 slots, and the slot the ignored write-one aimed at must hold the fill value, not the write-one value. The bench also requires `done` to fall after exactly one cycle.

// File: rtl/tt_pkg.sv
`timescale 1ns/1ps
package tt_pkg;

    typedef enum logic [1:0] {
        OP_PUT  = 2'd0,
        OP_GET  = 2'd1,
        OP_FILL = 2'd2,
        OP_LOAD = 2'd3
    } tt_op_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_CHECK = 3'd1,
        S_FETCH = 3'd2,
        S_WRITE = 3'd3,
        S_DONE  = 3'd4
    } tt_state_e;

    localparam int LOAD_MAX_PAGES = 512;
    localparam int LIST_ALIGN_BITS = 12;

    // Reverse byte order: lowest-address byte (bits 7..0) becomes the MSB.
    function automatic logic [63:0] swap_bytes(input logic [63:0] w);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) begin
            r[8*b +: 8] = w[8*(7-b) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/tt_lookup.sv
`timescale 1ns/1ps
module tt_lookup #(
    parameter int NTBL = 2,
    parameter int SEL_W = 1,
    parameter logic [NTBL-1:0][31:0] TBL_ID = '0,
    parameter logic [NTBL-1:0][63:0] TBL_OFF = '0,
    parameter logic [NTBL-1:0][5:0]  TBL_SHIFT = '0,
    parameter logic [NTBL-1:0][15:0] TBL_NENT = '0
) (
    input  logic [63:0]      tid,
    output logic             hit,
    output logic [SEL_W-1:0] sel,
    output logic [63:0]      off,
    output logic [5:0]       shift,
    output logic [15:0]      nent
);
    logic [NTBL-1:0] match;
    logic            upper_clear;

    assign upper_clear = (tid[63:32] == 32'd0);

    genvar g;
    generate
        for (g = 0; g < NTBL; g++) begin : g_match
            assign match[g] = upper_clear && (tid[31:0] == TBL_ID[g]);
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int t = 0; t < NTBL; t++) begin
            if (match[t] && !hit) begin
                hit = 1'b1;
                sel = SEL_W'(t);
            end
        end
        off   = TBL_OFF[sel];
        shift = TBL_SHIFT[sel];
        nent  = TBL_NENT[sel];
    end
endmodule

// File: rtl/tt_index.sv
`timescale 1ns/1ps
module tt_index (
    input  logic [63:0] addr,
    input  logic [63:0] off,
    input  logic [5:0]  shift,
    input  logic [15:0] nent,
    output logic [63:0] aligned,
    output logic [63:0] page,
    output logic [63:0] idx,
    output logic        in_range
);
    always_comb begin
        page     = 64'd1 << shift;
        aligned  = addr & ~(page - 64'd1);
        idx      = (aligned - off) >> shift;
        in_range = (idx < {48'd0, nent});
    end
endmodule

// File: rtl/tt_entry_ram.sv
`timescale 1ns/1ps
module tt_entry_ram #(
    parameter int NTBL = 2,
    parameter int DEPTH = 16,
    parameter int SEL_W = 1,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [IDX_W-1:0] idx,
    input  logic [63:0]      wdata,
    output logic [63:0]      rdata
);
    localparam int N  = NTBL * DEPTH;
    localparam int AW = (N > 1) ? $clog2(N) : 1;

    logic [63:0] mem [N];
    logic [AW-1:0] slot;

    assign slot  = AW'(sel) * AW'(DEPTH) + AW'(idx);
    assign rdata = mem[slot];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                mem[i] <= 64'd0;
            end
        end else if (we) begin
            mem[slot] <= wdata;
        end
    end
endmodule

// File: rtl/tt_cmd_engine.sv
`timescale 1ns/1ps
module tt_cmd_engine
    import tt_pkg::*;
#(
    parameter int NTBL  = 2,
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    parameter logic [NTBL-1:0][31:0] TBL_ID    = {32'h8000_0002, 32'h0000_0001},
    parameter logic [NTBL-1:0][63:0] TBL_OFF   = {64'h0000_0000_8000_0000, 64'h0},
    parameter logic [NTBL-1:0][5:0]  TBL_SHIFT = {6'd16, 6'd12},
    parameter logic [NTBL-1:0][15:0] TBL_NENT  = {16'd8, 16'd16}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [63:0]      cmd_tid,
    input  logic [63:0]      cmd_addr,
    input  logic [63:0]      cmd_data,
    input  logic [CNT_W-1:0] cmd_count,
    output logic             busy,
    output logic             done,
    output logic             done_err,
    output logic [63:0]      done_data,
    output logic             mem_req,
    output logic [63:0]      mem_addr,
    input  logic             mem_rvalid,
    input  logic [63:0]      mem_rdata
);
    localparam int SEL_W = (NTBL > 1) ? $clog2(NTBL) : 1;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        tt_state_e        st;
        tt_op_e           op;
        logic [63:0]      tid;
        logic [63:0]      addr;
        logic [63:0]      data;
        logic [63:0]      base;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] npg;
        logic             wait_rsp;
        logic             err;
        logic [63:0]      rdat;
    } regs_t;

    regs_t r_d, r_q;

    logic             hit;
    logic [SEL_W-1:0] sel;
    logic [63:0]      tbl_off;
    logic [5:0]       tbl_shift;
    logic [15:0]      tbl_nent;
    logic [63:0]      aligned, page, idx;
    logic             idx_ok;
    logic             ram_we;
    logic [63:0]      ram_rdata;
    logic [CNT_W-1:0] cnt_next;

    tt_lookup #(
        .NTBL(NTBL), .SEL_W(SEL_W), .TBL_ID(TBL_ID), .TBL_OFF(TBL_OFF),
        .TBL_SHIFT(TBL_SHIFT), .TBL_NENT(TBL_NENT)
    ) u_lookup (
        .tid(r_q.tid), .hit(hit), .sel(sel), .off(tbl_off),
        .shift(tbl_shift), .nent(tbl_nent)
    );

    tt_index u_index (
        .addr(r_q.addr), .off(tbl_off), .shift(tbl_shift), .nent(tbl_nent),
        .aligned(aligned), .page(page), .idx(idx), .in_range(idx_ok)
    );

    tt_entry_ram #(
        .NTBL(NTBL), .DEPTH(DEPTH), .SEL_W(SEL_W), .IDX_W(IDX_W)
    ) u_ram (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .sel(sel),
        .idx(idx[IDX_W-1:0]), .wdata(r_q.data), .rdata(ram_rdata)
    );

    assign cnt_next = r_q.cnt + CNT_W'(1);

    always_comb begin
        r_d     = r_q;
        ram_we  = 1'b0;
        mem_req = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    r_d.st       = S_CHECK;
                    r_d.op       = tt_op_e'(cmd_op);
                    r_d.tid      = cmd_tid;
                    r_d.addr     = cmd_addr;
                    r_d.data     = cmd_data;
                    r_d.base     = cmd_data;
                    r_d.npg      = cmd_count;
                    r_d.cnt      = '0;
                    r_d.wait_rsp = 1'b0;
                    r_d.err      = 1'b0;
                    r_d.rdat     = 64'd0;
                end
            end
            S_CHECK: begin
                r_d.addr = aligned;
                r_d.st   = S_DONE;
                r_d.err  = 1'b1;
                if (hit) begin
                    unique case (r_q.op)
                        OP_PUT: begin
                            r_d.st  = S_WRITE;
                            r_d.err = 1'b0;
                        end
                        OP_GET: begin
                            if (idx_ok) begin
                                r_d.err  = 1'b0;
                                r_d.rdat = ram_rdata;
                            end
                        end
                        OP_FILL: begin
                            if (r_q.npg != '0 && 32'(r_q.npg) <= 32'(tbl_nent)) begin
                                r_d.st  = S_WRITE;
                                r_d.err = 1'b0;
                            end
                        end
                        OP_LOAD: begin
                            if (r_q.npg != '0 && 32'(r_q.npg) <= 32'(LOAD_MAX_PAGES) &&
                                r_q.base[LIST_ALIGN_BITS-1:0] == '0) begin
                                r_d.st  = S_FETCH;
                                r_d.err = 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            S_FETCH: begin
                if (!r_q.wait_rsp) begin
                    mem_req      = 1'b1;
                    r_d.wait_rsp = 1'b1;
                end else if (mem_rvalid) begin
                    r_d.data     = swap_bytes(mem_rdata);
                    r_d.wait_rsp = 1'b0;
                    r_d.st       = S_WRITE;
                end
            end
            S_WRITE: begin
                if (!idx_ok) begin
                    r_d.err = 1'b1;
                    r_d.st  = S_DONE;
                end else begin
                    ram_we   = 1'b1;
                    r_d.cnt  = cnt_next;
                    r_d.addr = r_q.addr + page;
                    if (r_q.op == OP_PUT || cnt_next == r_q.npg) begin
                        r_d.st = S_DONE;
                    end else if (r_q.op == OP_LOAD) begin
                        r_d.st = S_FETCH;
                    end
                end
            end
            S_DONE: begin
                r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != S_IDLE);
    assign done      = (r_q.st == S_DONE);
    assign done_err  = r_q.err;
    assign done_data = r_q.rdat;
    assign mem_addr  = r_q.base + (64'(r_q.cnt) << 3);
endmodule

// File: rtl/tt_cmd_engine_chk.sv
`timescale 1ns/1ps
module tt_cmd_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic mem_req,
    input logic ram_we,
    input logic wr_in_range
);
    a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r6_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    a_r7_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r4_write_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> wr_in_range);

    a_r9_no_write_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ram_we);
endmodule

bind tt_cmd_engine tt_cmd_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
    .done(done), .mem_req(mem_req), .ram_we(ram_we), .wr_in_range(idx_ok)
);

// File: tb/tt_cmd_engine_bench.sv
`timescale 1ns/1ps
module tt_cmd_engine_bench;
    localparam logic [63:0] T0 = 64'h0000_0000_0000_0001;
    localparam logic [63:0] T1 = 64'h0000_0000_8000_0002;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [63:0] cmd_tid = '0, cmd_addr = '0, cmd_data = '0;
    logic [15:0] cmd_count = '0;
    logic        busy, done, done_err, mem_req;
    logic [63:0] done_data, mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    int vectors = 0;
    int fails = 0;
    int reads = 0;
    logic [63:0] model [2][16];

    always #2.5 clk = ~clk;

    tt_cmd_engine u_tt_cmd_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_tid(cmd_tid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_count(cmd_count), .busy(busy), .done(done), .done_err(done_err),
        .done_data(done_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [63:0] pattern(input logic [63:0] a);
        return {a[31:0] ^ 32'h1234_5678, ~a[31:0]};
    endfunction

    function automatic logic [63:0] entry_of(input logic [63:0] a);
        logic [63:0] r;
        r = pattern(a);
        return {r[7:0], r[15:8], r[23:16], r[31:24], r[39:32], r[47:40], r[55:48], r[63:56]};
    endfunction

    function automatic int tsel(input logic [63:0] tid);
        if (tid == T0) return 0;
        if (tid == T1) return 1;
        return -1;
    endfunction

    function automatic int shift_of(input int t); return (t == 1) ? 16 : 12; endfunction
    function automatic logic [63:0] off_of(input int t); return (t == 1) ? 64'h8000_0000 : 64'h0; endfunction
    function automatic int nent_of(input int t); return (t == 1) ? 8 : 16; endfunction

    // memory responder: one word per request, valid two edges later
    initial begin
        logic        pend;
        logic [63:0] pa;
        pend = 1'b0;
        pa = '0;
        forever begin
            @(negedge clk);
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
            end else if (pend) begin
                mem_rvalid = 1'b1;
                mem_rdata  = pattern(pa);
                pend = 1'b0;
            end
            if (mem_req) begin
                pend = 1'b1;
                pa = mem_addr;
                reads++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    task automatic model_cmd(input logic [1:0] op, input logic [63:0] tid, input logic [63:0] a,
                             input logic [63:0] v, input int np,
                             output logic est, output logic [63:0] ev, output int erd);
        int t;
        int sh;
        int ne;
        logic [63:0] ps, aa, ix, off;
        t = tsel(tid);
        est = 1'b0;
        ev = 64'd0;
        erd = 0;
        if (t < 0) begin
            est = 1'b1;
            return;
        end
        sh = shift_of(t);
        ne = nent_of(t);
        off = off_of(t);
        ps = 64'd1 << sh;
        aa = a & ~(ps - 64'd1);
        case (op)
            2'd0: begin
                ix = (aa - off) >> sh;
                if (ix < 64'(ne)) model[t][ix[3:0]] = v; else est = 1'b1;
            end
            2'd1: begin
                ix = (aa - off) >> sh;
                if (ix < 64'(ne)) ev = model[t][ix[3:0]]; else est = 1'b1;
            end
            2'd2: begin
                if (np == 0 || np > ne) est = 1'b1;
                else for (int i = 0; i < np; i++) begin
                    ix = (aa - off) >> sh;
                    if (ix >= 64'(ne)) begin est = 1'b1; break; end
                    model[t][ix[3:0]] = v;
                    aa += ps;
                end
            end
            default: begin
                if (np == 0 || np > 512 || v[11:0] != 12'd0) est = 1'b1;
                else for (int i = 0; i < np; i++) begin
                    erd++;
                    ix = (aa - off) >> sh;
                    if (ix >= 64'(ne)) begin est = 1'b1; break; end
                    model[t][ix[3:0]] = entry_of(v + 64'(8 * i));
                    aa += ps;
                end
            end
        endcase
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [63:0] tid, input logic [63:0] a,
                           input logic [63:0] v, input int np,
                           output logic st, output logic [63:0] rv, output int nr);
        @(negedge clk);
        cmd_op = op; cmd_tid = tid; cmd_addr = a; cmd_data = v; cmd_count = 16'(np);
        cmd_valid = 1'b1;
        reads = 0;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        st = done_err;
        rv = done_data;
        nr = reads;
    endtask

    task automatic apply(input logic [1:0] op, input logic [63:0] tid, input logic [63:0] a,
                         input logic [63:0] v, input int np, input string tag);
        logic est, st;
        logic [63:0] ev, rv;
        int erd, nr;
        model_cmd(op, tid, a, v, np, est, ev, erd);
        run_cmd(op, tid, a, v, np, st, rv, nr);
        chk(st == est, {tag, " status"}, 64'(st), 64'(est));
        chk(rv == ev, {tag, " data"}, rv, ev);
        if (op == 2'd3) chk(nr == erd, {tag, " reads"}, 64'(nr), 64'(erd));
    endtask

    // read back every entry of both tables (R5 get path)
    task automatic verify_tables(input string tag);
        for (int t = 0; t < 2; t++) begin
            for (int i = 0; i < nent_of(t); i++) begin
                logic [63:0] a;
                a = off_of(t) + (64'(i) << shift_of(t)) + 64'(i * 37);
                apply(2'd1, (t == 1) ? T1 : T0, a, 64'd0, 0, tag);
            end
        end
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 16; i++) model[t][i] = 64'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
        chk(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
        verify_tables("R1 reset contents");

        // R3 R4: write every slot through unaligned addresses
        for (int i = 0; i < 16; i++)
            apply(2'd0, T0, (64'(i) << 12) | 64'hABC, 64'hC0DE_0000_0000_0000 | 64'(i), 0, "R3 R4 put t0");
        for (int i = 0; i < 8; i++)
            apply(2'd0, T1, 64'h8000_0000 + (64'(i) << 16) + 64'h1234, 64'h5EED_0000_0000_0100 + 64'(i), 0, "R3 R4 put t1");
        verify_tables("R4 after puts");

        // R4 R5: out-of-range slots
        apply(2'd0, T0, 64'h1_0000, 64'hDEAD, 0, "R4 put past end");
        apply(2'd0, T1, 64'h1000, 64'hDEAD, 0, "R4 put below offset");
        apply(2'd1, T0, 64'h1_0FFF, 64'd0, 0, "R5 get past end");
        apply(2'd1, T1, 64'h8008_0000, 64'd0, 0, "R5 get past end t1");

        // R2: bad identifiers
        apply(2'd0, 64'h1_0000_0001, 64'h0, 64'hBAD, 0, "R2 upper bits");
        apply(2'd2, 64'h3, 64'h0, 64'hBAD, 4, "R2 no match");
        apply(2'd3, 64'hFFFF_FFFF_8000_0002, 64'h8000_0000, 64'h1000, 2, "R2 upper bits load");

        // R8 R9 R10: fills
        apply(2'd2, T0, 64'h3FFF, 64'hF111_0000_0000_0001, 5, "R8 fill");
        apply(2'd2, T0, 64'h0, 64'hF222, 17, "R8 fill too long");
        apply(2'd2, T1, 64'h8000_0000, 64'hF333, 8, "R8 fill whole t1");
        apply(2'd2, T0, 64'h0, 64'hF444, 0, "R10 fill zero");
        apply(2'd2, T0, 64'hE123, 64'hF555, 4, "R9 fill crosses end");
        verify_tables("R8 R9 after fills");

        // R6 R7 R9 R10: list copies
        apply(2'd3, T1, 64'h8001_0000, 64'h2000, 6, "R7 load");
        apply(2'd3, T0, 64'h2000, 64'h4000, 3, "R7 load t0");
        apply(2'd3, T0, 64'h0, 64'h2008, 2, "R6 load misaligned");
        apply(2'd3, T0, 64'h0, 64'h2000, 513, "R6 load too long");
        apply(2'd3, T0, 64'h0, 64'h2000, 0, "R10 load zero");
        apply(2'd3, T0, 64'hD000, 64'h6000, 5, "R9 load crosses end");
        verify_tables("R7 R9 after loads");
        apply(2'd3, T0, 64'h0, 64'h3000, 512, "R6 R9 load max count");
        verify_tables("R7 after max load");

        // R11: command presented while busy is ignored; done is one cycle
        begin
            logic est; logic [63:0] ev; int erd;
            model_cmd(2'd2, T0, 64'h0, 64'h0A0A_0A0A_0A0A_0A0A, 16, est, ev, erd);
            @(negedge clk);
            cmd_op = 2'd2; cmd_tid = T0; cmd_addr = 64'h0; cmd_data = 64'h0A0A_0A0A_0A0A_0A0A;
            cmd_count = 16'd16; cmd_valid = 1'b1;
            @(negedge clk);
            chk(busy == 1'b1, "R11 busy after accept", 64'(busy), 64'd1);
            cmd_op = 2'd0; cmd_addr = 64'h5000; cmd_data = 64'h0BAD_0BAD;
            repeat (3) @(negedge clk);
            cmd_valid = 1'b0;
            while (!done) @(negedge clk);
            chk(done_err == est, "R11 fill status", 64'(done_err), 64'(est));
            @(negedge clk);
            chk(done == 1'b0, "R11 done single cycle", 64'(done), 64'd0);
            chk(busy == 1'b0, "R11 idle after done", 64'(busy), 64'd0);
            verify_tables("R11 after ignored command");
        end

        finish_run();
    end
endmodule